// File: doc/BRIEF.md
# Packed Widening Multiplier (Integer and Carry-less)

This unit takes two 64-bit source words and multiplies them lane by lane into a 128-bit result, where every product lane is twice as wide as its source lane. A single datapath serves signed integer, unsigned integer and carry-less (GF(2) polynomial) lane products. A two-bit width code picks 8, 16 or 32-bit source lanes, and one polynomial form treats each source as a single 64-bit lane.

A producer offers an operation with a valid/ready handshake. Two cycles later the outcome appears on the output handshake and stays there until the consumer takes it. Operations that are not legal encodings come out with an undefined flag and an all-zero result instead of a product. Latency is the same for every mode and every operand value.

Top module: `simd_mull_unit`

## Requirements
- R1: Source lane width is 8 << sizeCode for sizeCode 00, 01 and 10 (8, 16, 32 bits), and the lane count is 64 divided by that width. Product lane k occupies result bits [2W·k +: 2W], so lane 0 sits in the least significant bits.
- R2: With isPoly=0 and isUnsigned=0, each source lane is sign-extended. The stored lane is the low 2W bits of the exact signed product (for example, 8-bit lanes 0xFF × 0xFF give 0x0001).
- R3: With isPoly=0 and isUnsigned=1, each source lane is zero-extended and the stored lane is the exact unsigned product (for example, 0xFF × 0xFF gives 0xFE01).
- R4: With isPoly=1, isUnsigned=0 and sizeCode=00, each 8-bit lane pair gives a 16-bit carry-less product: the XOR of shifted copies of one operand (for example, 0xFF × 0xFF gives 0x5555).
- R5: With isPoly=1, isUnsigned=0 and sizeCode=10, and parameter WIDE_CLMUL=1, the whole 64-bit sources give one 128-bit carry-less product. With WIDE_CLMUL=0, this combination is undefined.
- R6: sizeCode=11 is undefined in every mode.
- R7: With isPoly=1, isUnsigned=1 or sizeCode=01 is undefined.
- R8: dstIdxLsb=1 (an odd destination register index) is undefined in every mode.
- R9: An undefined operation completes through the handshake with undefOp=1 and result equal to zero. Every legal operation completes with undefOp=0.
- R10: When the consumer is ready, outValid rises exactly two clock edges after the edge that accepts an input. This holds for every mode, for undefined encodings and for any operand value. Inputs are accepted back to back.
- R11: While outValid=1 and outReady=0, the result and undefOp hold steady, inReady is 0, and no new input is taken. The held input enters on the edge where the output is consumed.
- R12: After reset, outValid=0, undefOp=0, result=0 and inReady=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Producer offers an operation |
| inReady | output | 1 | Unit accepts the offered operation on this edge |
| opA | input | 64 | First source word |
| opB | input | 64 | Second source word |
| isPoly | input | 1 | 1 selects carry-less multiplication |
| isUnsigned | input | 1 | 1 selects zero extension of integer lanes |
| sizeCode | input | 2 | Lane width code |
| dstIdxLsb | input | 1 | Least significant bit of the destination register index |
| outValid | output | 1 | Result is present |
| outReady | input | 1 | Consumer takes the result on this edge |
| result | output | 128 | Packed double-width lane products |
| undefOp | output | 1 | Operation was an illegal encoding |

## Verification
Two events can land on the same edge: the consumer draining a held result, and a waiting producer's operation being accepted. One test stalls the output with outReady low while a second operation is already offered. Across the stall, result must stay frozen and inReady must stay low. On the release edge the old result must leave and the new operation must enter, and the new product must arrive two edges later. A streaming run with a periodic outReady pattern mixes every mode and an undefined encoding. It checks that results come out in order with none lost or repeated.

// File: rtl/mull_pkg.sv
package mull_pkg;

  typedef enum logic [2:0] {
    KIND_INT8   = 3'd0,
    KIND_INT16  = 3'd1,
    KIND_INT32  = 3'd2,
    KIND_POLY8  = 3'd3,
    KIND_POLY64 = 3'd4
  } laneKind_e;

  typedef struct packed {
    logic      loadEn;
    logic      computeEn;
    laneKind_e kind;
    logic      signedOp;
    logic      undef;
  } mullStrobe_t;

endpackage

// File: rtl/mull_clmul_lane.sv
module mull_clmul_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int PW = 2 * W;

  always_comb begin
    p = '0;
    for (int i = 0; i < W; i++) begin
      if (b[i]) p = p ^ ({{W{1'b0}}, a} << i);
    end
  end

  logic [PW-1:0] unusedGuard;
  assign unusedGuard = p;
endmodule

// File: rtl/mull_ctrl.sv
module mull_ctrl
  import mull_pkg::*;
#(
  parameter bit WIDE_CLMUL = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output logic        inReady,
  input  logic        isPoly,
  input  logic        isUnsigned,
  input  logic [1:0]  sizeCode,
  input  logic        dstIdxLsb,
  output logic        outValid,
  input  logic        outReady,
  output logic        undefOp,
  output mullStrobe_t strobe
);
  logic      stepEn;
  logic      decUndef;
  laneKind_e decKind;
  logic      s1Valid;
  logic      s1Undef;
  logic      s1Signed;
  laneKind_e s1Kind;

  assign stepEn  = !outValid || outReady;
  assign inReady = stepEn;

  always_comb begin
    decUndef = (sizeCode == 2'b11) || dstIdxLsb;
    decKind  = KIND_INT8;
    if (isPoly) begin
      if (isUnsigned || sizeCode == 2'b01) decUndef = 1'b1;
      if (sizeCode == 2'b10) begin
        decKind = KIND_POLY64;
        if (!WIDE_CLMUL) decUndef = 1'b1;
      end else begin
        decKind = KIND_POLY8;
      end
    end else begin
      case (sizeCode)
        2'b00:   decKind = KIND_INT8;
        2'b01:   decKind = KIND_INT16;
        default: decKind = KIND_INT32;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      s1Undef  <= 1'b0;
      s1Signed <= 1'b0;
      s1Kind   <= KIND_INT8;
      outValid <= 1'b0;
      undefOp  <= 1'b0;
    end else if (stepEn) begin
      s1Valid  <= inValid;
      outValid <= s1Valid;
      if (inValid) begin
        s1Undef  <= decUndef;
        s1Signed <= !isUnsigned && !isPoly;
        s1Kind   <= decKind;
      end
      if (s1Valid) undefOp <= s1Undef;
    end
  end

  always_comb begin
    strobe.loadEn    = stepEn && inValid;
    strobe.computeEn = stepEn && s1Valid;
    strobe.kind      = s1Kind;
    strobe.signedOp  = s1Signed;
    strobe.undef     = s1Undef;
  end
endmodule

// File: rtl/mull_datapath.sv
module mull_datapath
  import mull_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter bit WIDE_CLMUL = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  mullStrobe_t         strobe,
  output logic [2*DATA_W-1:0] result
);
  localparam int RES_W   = 2 * DATA_W;
  localparam int N_INT   = 3;
  localparam int P8_W    = 8;
  localparam int P8_LANE = DATA_W / P8_W;

  logic [DATA_W-1:0] aReg;
  logic [DATA_W-1:0] bReg;
  logic [RES_W-1:0]  intRes [N_INT];
  logic [RES_W-1:0]  poly8Res;
  logic [RES_W-1:0]  poly64Res;
  logic [RES_W-1:0]  selRes;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aReg <= '0;
      bReg <= '0;
    end else if (strobe.loadEn) begin
      aReg <= opA;
      bReg <= opB;
    end
  end

  for (genvar g = 0; g < N_INT; g++) begin : gIntWidth
    localparam int W = 8 << g;
    localparam int N = DATA_W / W;
    logic [RES_W-1:0] laneRes;
    for (genvar l = 0; l < N; l++) begin : gLane
      logic signed [W:0]     extA;
      logic signed [W:0]     extB;
      logic signed [2*W-1:0] prod;
      assign extA = {strobe.signedOp & aReg[l*W+W-1], aReg[l*W +: W]};
      assign extB = {strobe.signedOp & bReg[l*W+W-1], bReg[l*W +: W]};
      assign prod = extA * extB;
      assign laneRes[l*2*W +: 2*W] = prod;
    end
    assign intRes[g] = laneRes;
  end

  for (genvar l = 0; l < P8_LANE; l++) begin : gPoly8
    mull_clmul_lane #(.W(P8_W)) u_lane (
      .a(aReg[l*P8_W +: P8_W]),
      .b(bReg[l*P8_W +: P8_W]),
      .p(poly8Res[l*2*P8_W +: 2*P8_W])
    );
  end

  if (WIDE_CLMUL) begin : gWide
    mull_clmul_lane #(.W(DATA_W)) u_wide (
      .a(aReg),
      .b(bReg),
      .p(poly64Res)
    );
  end else begin : gNoWide
    assign poly64Res = '0;
  end

  always_comb begin
    case (strobe.kind)
      KIND_INT8:   selRes = intRes[0];
      KIND_INT16:  selRes = intRes[1];
      KIND_INT32:  selRes = intRes[2];
      KIND_POLY8:  selRes = poly8Res;
      KIND_POLY64: selRes = poly64Res;
      default:     selRes = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) result <= '0;
    else if (strobe.computeEn) result <= strobe.undef ? '0 : selRes;
  end
endmodule

// File: rtl/simd_mull_unit.sv
module simd_mull_unit
  import mull_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter bit WIDE_CLMUL = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  output logic                inReady,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic                isPoly,
  input  logic                isUnsigned,
  input  logic [1:0]          sizeCode,
  input  logic                dstIdxLsb,
  output logic                outValid,
  input  logic                outReady,
  output logic [2*DATA_W-1:0] result,
  output logic                undefOp
);
  mullStrobe_t strobe;

  mull_ctrl #(.WIDE_CLMUL(WIDE_CLMUL)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .isPoly(isPoly), .isUnsigned(isUnsigned), .sizeCode(sizeCode),
    .dstIdxLsb(dstIdxLsb), .outValid(outValid), .outReady(outReady),
    .undefOp(undefOp), .strobe(strobe)
  );

  mull_datapath #(.DATA_W(DATA_W), .WIDE_CLMUL(WIDE_CLMUL)) u_dp (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB),
    .strobe(strobe), .result(result)
  );
endmodule

// File: rtl/simd_mull_unit_chk.sv
module simd_mull_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic                inReady,
  input logic [1:0]          sizeCode,
  input logic                dstIdxLsb,
  input logic                outValid,
  input logic                outReady,
  input logic [2*DATA_W-1:0] result,
  input logic                undefOp
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(result) && $stable(undefOp)); // R11

  AST_STALL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady); // R11

  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    outValid && undefOp |-> result == '0); // R9

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && inReady, 2) && $past(outReady, 1) |-> outValid); // R10

  AST_SIZE3_UNDEF: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && inReady && sizeCode == 2'b11, 2) && $past(outReady, 1) |-> undefOp); // R6

  AST_ODD_DST_UNDEF: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid && inReady && dstIdxLsb, 2) && $past(outReady, 1) |-> undefOp); // R8
endmodule

bind simd_mull_unit simd_mull_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .sizeCode(sizeCode), .dstIdxLsb(dstIdxLsb), .outValid(outValid),
  .outReady(outReady), .result(result), .undefOp(undefOp)
);

// File: tb/simd_mull_unit_bench.sv
module simd_mull_unit_bench;
  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic         inReady;
  logic [63:0]  opA;
  logic [63:0]  opB;
  logic         isPoly;
  logic         isUnsigned;
  logic [1:0]   sizeCode;
  logic         dstIdxLsb;
  logic         outValid;
  logic         outReady;
  logic [127:0] result;
  logic         undefOp;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  simd_mull_unit u_simd_mull_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .opA(opA), .opB(opB), .isPoly(isPoly), .isUnsigned(isUnsigned),
    .sizeCode(sizeCode), .dstIdxLsb(dstIdxLsb), .outValid(outValid),
    .outReady(outReady), .result(result), .undefOp(undefOp)
  );

  task automatic check(input bit ok, input string req, input logic [128:0] act, input logic [128:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] refInt(input logic [63:0] a, input logic [63:0] b, input int w, input bit uns);
    logic [127:0] r;
    longint va, vb, p;
    logic [63:0] m1, m2, pu;
    r  = '0;
    m1 = (w == 32) ? 64'hFFFF_FFFF : ((64'd1 << w) - 1);
    m2 = (w == 32) ? '1 : ((64'd1 << (2 * w)) - 1);
    for (int l = 0; l < 64 / w; l++) begin
      va = longint'((a >> (l * w)) & m1);
      vb = longint'((b >> (l * w)) & m1);
      if (!uns && va[w-1]) va = va - (longint'(1) << w);
      if (!uns && vb[w-1]) vb = vb - (longint'(1) << w);
      p  = va * vb;
      pu = 64'(p) & m2;
      r  = r | ({64'b0, pu} << (l * 2 * w));
    end
    return r;
  endfunction

  function automatic logic [127:0] refPoly(input logic [63:0] a, input logic [63:0] b, input int w);
    logic [127:0] r, p, ea;
    logic [63:0] m1, eb;
    r  = '0;
    m1 = (w == 64) ? '1 : ((64'd1 << w) - 1);
    for (int l = 0; l < 64 / w; l++) begin
      ea = {64'b0, (a >> (l * w)) & m1};
      eb = (b >> (l * w)) & m1;
      p  = '0;
      for (int i = 0; i < w; i++) if (eb[i]) p = p ^ (ea << i);
      r = r | (p << (l * 2 * w));
    end
    return r;
  endfunction

  function automatic logic [128:0] refAny(input logic [63:0] a, input logic [63:0] b,
                                          input bit poly, input bit uns, input logic [1:0] sz, input bit odd);
    bit bad;
    bad = (sz == 2'b11) || odd || (poly && (uns || sz == 2'b01));
    if (bad) return {1'b1, 128'b0};
    if (poly) return {1'b0, refPoly(a, b, (sz == 2'b10) ? 64 : 8)};
    return {1'b0, refInt(a, b, 8 << sz, uns)};
  endfunction

  // Called at a negedge with an idle or draining pipeline; returns at a negedge.
  task automatic doOp(input logic [63:0] a, input logic [63:0] b, input bit poly, input bit uns,
                      input logic [1:0] sz, input bit odd, output logic [127:0] res,
                      output logic und, output int lat);
    opA = a; opB = b; isPoly = poly; isUnsigned = uns; sizeCode = sz; dstIdxLsb = odd;
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    lat = 1;
    while (!outValid && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    res = result;
    und = undefOp;
  endtask

  task automatic runCheck(input logic [63:0] a, input logic [63:0] b, input bit poly, input bit uns,
                          input logic [1:0] sz, input bit odd, input string req);
    logic [127:0] res;
    logic         und;
    int           lat;
    logic [128:0] exp;
    exp = refAny(a, b, poly, uns, sz, odd);
    doOp(a, b, poly, uns, sz, odd, res, und, lat);
    check({und, res} === exp, req, {und, res}, exp);
    check(lat == 2, "R10 latency", 129'(lat), 129'd2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [63:0]  a, b, lfsr;
    logic [127:0] res, r0;
    logic         und;
    int           lat;
    logic [63:0]  sa [8];
    logic [63:0]  sb [8];
    bit           sp [8];
    bit           su [8];
    logic [1:0]   ss [8];
    bit           sd [8];
    int           sent, got;

    rstN = 1'b0; inValid = 1'b0; outReady = 1'b1; opA = '0; opB = '0;
    isPoly = 1'b0; isUnsigned = 1'b0; sizeCode = 2'b00; dstIdxLsb = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(!outValid && !undefOp && result == '0 && inReady, "R12 reset state",
          {undefOp, result}, 129'b0);

    // Named corner cases: 0xFF x 0xFF in every 8-bit lane
    doOp({8{8'hFF}}, {8{8'hFF}}, 1'b0, 1'b0, 2'b00, 1'b0, res, und, lat);
    check(res == {8{16'h0001}} && !und, "R2 s8 0xFF*0xFF", {und, res}, {1'b0, {8{16'h0001}}});
    doOp({8{8'hFF}}, {8{8'hFF}}, 1'b0, 1'b1, 2'b00, 1'b0, res, und, lat);
    check(res == {8{16'hFE01}} && !und, "R3 u8 0xFF*0xFF", {und, res}, {1'b0, {8{16'hFE01}}});
    doOp({8{8'hFF}}, {8{8'hFF}}, 1'b1, 1'b0, 2'b00, 1'b0, res, und, lat);
    check(res == {8{16'h5555}} && !und, "R4 p8 0xFF*0xFF", {und, res}, {1'b0, {8{16'h5555}}});
    doOp('1, '1, 1'b1, 1'b0, 2'b10, 1'b0, res, und, lat);
    check(res == {32{4'h5}} && !und, "R5 p64 all ones", {und, res}, {1'b0, {32{4'h5}}});
    // R1 lane order: only lane 0 and lane 3 loaded in 16-bit lanes
    doOp(64'h0003_0000_0000_0002, 64'h0005_0000_0000_0007, 1'b0, 1'b1, 2'b01, 1'b0, res, und, lat);
    check(res == 128'h0000_000F_0000_0000_0000_0000_0000_000E, "R1 lane placement",
          {und, res}, {1'b0, 128'h0000_000F_0000_0000_0000_0000_0000_000E});

    // Near-exhaustive 8-bit sweep: signed, unsigned, carry-less (R1 R2 R3 R4)
    for (int md = 0; md < 3; md++) begin
      for (int i = 0; i < 256; i++) begin
        for (int jb = 0; jb < 32; jb++) begin
          a = {8{i[7:0]}};
          for (int l = 0; l < 8; l++) b[l*8 +: 8] = 8'(jb * 8 + l);
          runCheck(a, b, md == 2, md == 1, 2'b00, 1'b0,
                   md == 0 ? "R2 s8 sweep" : (md == 1 ? "R3 u8 sweep" : "R4 p8 sweep"));
        end
      end
    end

    // 16/32-bit extremes and pseudo-random words (R1 R2 R3), 64-bit carry-less (R5)
    runCheck({4{16'h8000}}, {4{16'h8000}}, 1'b0, 1'b0, 2'b01, 1'b0, "R2 s16 min*min");
    runCheck({4{16'hFFFF}}, {4{16'h7FFF}}, 1'b0, 1'b1, 2'b01, 1'b0, "R3 u16 extremes");
    runCheck({2{32'h8000_0000}}, {2{32'h7FFF_FFFF}}, 1'b0, 1'b0, 2'b10, 1'b0, "R2 s32 extremes");
    runCheck('1, '1, 1'b0, 1'b1, 2'b10, 1'b0, "R3 u32 all ones");
    lfsr = 64'h1D87_2B41_9C3E_A6F5;
    for (int k = 0; k < 1200; k++) begin
      a    = lfsr;
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      b    = lfsr ^ {lfsr[31:0], lfsr[63:32]};
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      case (k % 5)
        0: runCheck(a, b, 1'b0, 1'b0, 2'b01, 1'b0, "R2 s16 random");
        1: runCheck(a, b, 1'b0, 1'b1, 2'b01, 1'b0, "R3 u16 random");
        2: runCheck(a, b, 1'b0, 1'b0, 2'b10, 1'b0, "R2 s32 random");
        3: runCheck(a, b, 1'b0, 1'b1, 2'b10, 1'b0, "R3 u32 random");
        default: runCheck(a, b, 1'b1, 1'b0, 2'b10, 1'b0, "R5 p64 random");
      endcase
    end

    // Undefined encodings (R6 R7 R8 R9)
    runCheck(64'h1234, 64'h5678, 1'b0, 1'b0, 2'b11, 1'b0, "R6 int size 11");
    runCheck(64'h1234, 64'h5678, 1'b1, 1'b0, 2'b11, 1'b0, "R6 poly size 11");
    runCheck(64'h1234, 64'h5678, 1'b1, 1'b1, 2'b00, 1'b0, "R7 poly unsigned");
    runCheck(64'h1234, 64'h5678, 1'b1, 1'b0, 2'b01, 1'b0, "R7 poly size 01");
    runCheck(64'h1234, 64'h5678, 1'b0, 1'b1, 2'b00, 1'b1, "R8 odd destination");
    runCheck('1, '1, 1'b1, 1'b0, 2'b10, 1'b1, "R8 R9 odd dst p64");

    // Stall with a waiting producer (R11)
    @(negedge clk);
    outReady = 1'b0;
    opA = {8{8'h9C}}; opB = {8{8'h3B}}; isPoly = 1'b0; isUnsigned = 1'b0;
    sizeCode = 2'b00; dstIdxLsb = 1'b0; inValid = 1'b1;
    @(posedge clk); @(negedge clk);
    inValid = 1'b0;
    @(posedge clk); @(negedge clk);
    r0 = result;
    check(outValid && {undefOp, r0} == refAny({8{8'h9C}}, {8{8'h3B}}, 0, 0, 2'b00, 0),
          "R11 first result", {undefOp, r0}, refAny({8{8'h9C}}, {8{8'h3B}}, 0, 0, 2'b00, 0));
    opA = 64'hDEAD_BEEF_0BAD_F00D; opB = 64'h0123_4567_89AB_CDEF; isPoly = 1'b1;
    sizeCode = 2'b10; inValid = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(posedge clk); @(negedge clk);
      check(outValid && result == r0 && !inReady, "R11 held while stalled",
            {~inReady, result}, {1'b0, r0});
    end
    outReady = 1'b1;
    @(posedge clk); @(negedge clk);
    inValid = 1'b0;
    check(!outValid, "R11 drained on release", 129'(outValid), 129'd0);
    @(posedge clk); @(negedge clk);
    check(outValid && {undefOp, result} == refAny(64'hDEAD_BEEF_0BAD_F00D, 64'h0123_4567_89AB_CDEF, 1, 0, 2'b10, 0),
          "R11 waiting op enters on release", {undefOp, result},
          refAny(64'hDEAD_BEEF_0BAD_F00D, 64'h0123_4567_89AB_CDEF, 1, 0, 2'b10, 0));
    @(posedge clk); @(negedge clk);

    // Streaming with a periodic consumer stall (R10 R11)
    for (int k = 0; k < 8; k++) begin
      sa[k] = 64'h0F1E_2D3C_4B5A_6978 * 64'(k + 3);
      sb[k] = 64'hF0E1_D2C3_B4A5_9687 ^ (64'(k) << 13);
      sp[k] = (k == 5) || (k == 2);
      su[k] = (k == 1) || (k == 3);
      ss[k] = (k == 5) ? 2'b10 : ((k == 6) ? 2'b11 : 2'(k % 3));
      if (k == 2) ss[k] = 2'b00;
      sd[k] = 1'b0;
    end
    sent = 0; got = 0;
    for (int cyc = 0; cyc < 80 && got < 8; cyc++) begin
      outReady = (cyc % 3) != 1;
      inValid  = sent < 8;
      if (sent < 8) begin
        opA = sa[sent]; opB = sb[sent]; isPoly = sp[sent]; isUnsigned = su[sent];
        sizeCode = ss[sent]; dstIdxLsb = sd[sent];
      end
      #1;
      if (outValid && outReady) begin
        check({undefOp, result} === refAny(sa[got], sb[got], sp[got], su[got], ss[got], sd[got]),
              "R10 stream order", {undefOp, result},
              refAny(sa[got], sb[got], sp[got], su[got], ss[got], sd[got]));
        got++;
      end
      if (inValid && inReady) sent++;
      @(posedge clk); @(negedge clk);
    end
    check(got == 8, "R10 stream complete", 129'(got), 129'd8);
    inValid = 1'b0; outReady = 1'b1;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule